// File: doc/BRIEF.md
# Phase-Accumulator PWM Channel with Latched Reconfiguration

This block drives one pulse-width-modulated output from a single 32-bit control word. A phase accumulator adds a programmable step on every clock. The step sets the output frequency, and each wrap of the accumulator starts a new output period. An 8-bit divider field sets the duty cycle. This field is stored inverted, so a larger value gives a shorter high time.

Software writes the step and the divider into a shadow copy. The output runs from a separate active copy. The shadow copy moves into the active copy only after software sets the update-request bit in a write. While the output is running, the move happens at the next period boundary. While the output is disabled, it happens on the next clock. The hardware clears the request bit when the move happens. A write that arrives while a request is still pending is dropped, so the pending update cannot be corrupted. Software polls the request bit until it reads zero and then issues the next write.

Top module: `pacc_pwm`

## Requirements
- R1: After reset, `rd_data` reads 0, `pwm_out` is low, and the accumulator is zero.
- R2: `rd_data` holds the enable flag in bit 31 and the pending-update flag in bit 30. It holds the shadow step in bits `8 +: BASE_BITS` and the shadow divider in bits 7:0. All other bits read 0.
- R3: When the output is enabled with a nonzero active step S, the accumulator wraps every 2^BASE_BITS/S clocks. When the duty is strictly between 0 and full, `pwm_out` has exactly one rising edge in each such period.
- R4: While enabled, `pwm_out` is high for each clock whose accumulator top 8 bits are below 255 minus the active divider, and low otherwise. The output register delays this by one clock.
- R5: While enabled, a pending update loads the active step and divider, and clears bit 30, on the same clock edge where the accumulator wraps. Before that edge the request stays pending.
- R6: A write accepted while bit 30 reads 1 changes nothing. The enable bit, the shadow fields, the pending request and the active configuration all stay as they were.
- R7: While disabled, a pending update completes on the next clock edge.
- R8: Clearing the enable bit drives `pwm_out` low by the second clock edge and holds it low. Setting the enable bit starts a new period from a zero accumulator.
- R9: With an active step of zero, `pwm_out` stays low even while enabled.
- R10: A write with bit 30 clear updates only the shadow fields and the enable bit. The running output keeps its active step and divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the accumulator advances on each rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| wr_data | input | 32 | Control word to write (layout as in R2) |
| rd_data | output | 32 | Current control word (layout as in R2) |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The assertions assume that software does not request an update while the block is enabled with a zero active step. In that state no wrap ever comes, so the request would stay pending. They also assume that `wr_en` is a single-cycle strobe with a known value after reset. The bench always loads a configuration with the output disabled before it enables the output. It only requests updates on the fly when the active step is nonzero, and it polls bit 30 before each new request, except in the one deliberate lockout case.

// File: rtl/pacc_pwm_pkg.sv
package pacc_pwm_pkg;
  localparam int CTRL_W   = 32;
  localparam int EN_POS   = 31;
  localparam int UPD_POS  = 30;
  localparam int STEP_LSB = 8;
  localparam int DIV_W    = 8;
  localparam int DIV_MAX  = (1 << DIV_W) - 1;

  typedef logic [DIV_W-1:0] div_t;
endpackage

// File: rtl/pacc_pwm_regs.sv
module pacc_pwm_regs
  import pacc_pwm_pkg::*;
#(
  parameter int BASE_BITS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [CTRL_W-1:0]    wr_data,
  input  logic                 wrap,
  output logic                 enable,
  output logic                 pending,
  output logic [BASE_BITS-1:0] sh_step,
  output div_t                 sh_div,
  output logic [BASE_BITS-1:0] act_step,
  output div_t                 act_div
);
  // accepted write: only when no request is outstanding
  logic take_wr;
  // shadow moves to active at a period edge, or at once while idle
  logic commit;

  assign take_wr = wr_en && !pending;
  assign commit  = pending && (wrap || !enable);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable   <= 1'b0;
      pending  <= 1'b0;
      sh_step  <= '0;
      sh_div   <= '0;
      act_step <= '0;
      act_div  <= '0;
    end else if (take_wr) begin
      enable  <= wr_data[EN_POS];
      pending <= wr_data[UPD_POS];
      sh_step <= wr_data[STEP_LSB +: BASE_BITS];
      sh_div  <= wr_data[DIV_W-1:0];
    end else if (commit) begin
      act_step <= sh_step;
      act_div  <= sh_div;
      pending  <= 1'b0;
    end
  end
endmodule

// File: rtl/pacc_pwm_phase.sv
module pacc_pwm_phase #(
  parameter int BASE_BITS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic [BASE_BITS-1:0] step,
  output logic [BASE_BITS-1:0] acc,
  output logic                 wrap
);
  localparam int SUM_W = BASE_BITS + 1;

  logic [SUM_W-1:0] sum;

  assign sum  = {1'b0, acc} + {1'b0, step};
  assign wrap = run && sum[SUM_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      acc <= '0;
    end else begin
      acc <= sum[BASE_BITS-1:0];
    end
  end
endmodule

// File: rtl/pacc_pwm_cmp.sv
module pacc_pwm_cmp
  import pacc_pwm_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic step_zero,
  input  div_t phase_top,
  input  div_t inv_div,
  output logic pwm_out
);
  div_t high_lim;
  logic level;

  // the stored field is inverted: high span is 255 minus the field
  assign high_lim = div_t'(DIV_MAX) - inv_div;
  assign level    = run && !step_zero && (phase_top < high_lim);

  generate
    if (OUT_REG) begin : g_reg
      logic out_q;
      always_ff @(posedge clk) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= level;
      end
      assign pwm_out = out_q;
    end else begin : g_comb
      assign pwm_out = level;
    end
  endgenerate
endmodule

// File: rtl/pacc_pwm.sv
module pacc_pwm
  import pacc_pwm_pkg::*;
#(
  parameter int BASE_BITS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        pwm_out
);
  localparam int TOP_LSB = BASE_BITS - DIV_W;

  logic                 enable;
  logic                 pending;
  logic [BASE_BITS-1:0] sh_step;
  div_t                 sh_div;
  logic [BASE_BITS-1:0] act_step;
  div_t                 act_div;
  logic [BASE_BITS-1:0] phase_acc;
  logic                 phase_wrap;

  pacc_pwm_regs #(.BASE_BITS(BASE_BITS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .wrap     (phase_wrap),
    .enable   (enable),
    .pending  (pending),
    .sh_step  (sh_step),
    .sh_div   (sh_div),
    .act_step (act_step),
    .act_div  (act_div)
  );

  pacc_pwm_phase #(.BASE_BITS(BASE_BITS)) u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (enable),
    .step  (act_step),
    .acc   (phase_acc),
    .wrap  (phase_wrap)
  );

  pacc_pwm_cmp #(.OUT_REG(1'b1)) u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (enable),
    .step_zero (act_step == '0),
    .phase_top (phase_acc[TOP_LSB +: DIV_W]),
    .inv_div   (act_div),
    .pwm_out   (pwm_out)
  );

  always_comb begin
    rd_data                        = '0;
    rd_data[EN_POS]                = enable;
    rd_data[UPD_POS]               = pending;
    rd_data[STEP_LSB +: BASE_BITS] = sh_step;
    rd_data[DIV_W-1:0]             = sh_div;
  end
endmodule

// File: rtl/pacc_pwm_chk.sv
module pacc_pwm_chk #(
  parameter int BASE_BITS = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [31:0]          rd_data,
  input logic                 pwm_out,
  input logic                 wrap,
  input logic [BASE_BITS-1:0] act_step
);
  AST_LOCKOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_data[30]) |=> (rd_data[29:0] == $past(rd_data[29:0]) &&
                                rd_data[31] == $past(rd_data[31]))); // R6

  AST_IDLE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[30] && !rd_data[31]) |=> !rd_data[30]); // R7

  AST_HOLD_TO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[30] && rd_data[31] && !wrap) |=> rd_data[30]); // R5

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[31] |=> !pwm_out); // R8

  AST_ZERO_STEP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (act_step == '0) |=> !pwm_out); // R9

  AST_NO_STRAY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rd_data[29:8+BASE_BITS] == '0)); // R2
endmodule

bind pacc_pwm pacc_pwm_chk #(.BASE_BITS(BASE_BITS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .rd_data  (rd_data),
  .pwm_out  (pwm_out),
  .wrap     (phase_wrap),
  .act_step (act_step)
);

// File: tb/pacc_pwm_tb.sv
module pacc_pwm_tb;
  localparam int BB = 12;
  localparam int NV = 7;
  // each entry: step(12) div(8) expected high clocks(10) period(10)
  localparam logic [39:0] VEC [NV] = '{
    {12'd16,  8'd0,   10'd255, 10'd256},
    {12'd16,  8'd128, 10'd127, 10'd256},
    {12'd16,  8'd255, 10'd0,   10'd256},
    {12'd32,  8'd127, 10'd64,  10'd128},
    {12'd64,  8'd200, 10'd14,  10'd64},
    {12'd128, 8'd0,   10'd32,  10'd32},
    {12'd16,  8'd254, 10'd1,   10'd256}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        pwm_out;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  pacc_pwm #(.BASE_BITS(BB)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pwm_out(pwm_out)
  );

  function automatic logic [31:0] word(input bit en, input bit upd,
                                       input int step, input int dv);
    logic [31:0] w;
    w = '0;
    w[31] = en;
    w[30] = upd;
    w[8 +: BB] = step[BB-1:0];
    w[7:0] = dv[7:0];
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    wr_data = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic measure(input int len, output int hi, output int rises);
    bit prev;
    hi = 0;
    rises = 0;
    prev = pwm_out;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (pwm_out) hi++;
      if (pwm_out && !prev) rises++;
      prev = pwm_out;
    end
  endtask

  task automatic poll_idle();
    int n = 0;
    while (rd_data[30] && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check(!rd_data[30], "R5 request completes", rd_data[30], 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int hi, rises, exp_rise, step, dv, ehi, per;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(rd_data == 32'h0, "R1 reset readback", rd_data, 0);
    check(pwm_out == 1'b0, "R1 reset output", pwm_out, 0);

    // R7 preload while disabled: commits on next edge
    wr(word(0, 1, 16, 0));
    check(rd_data[30] == 1'b1, "R7 request seen", rd_data[30], 1);
    @(negedge clk);
    check(rd_data[30] == 1'b0, "R7 idle commit next clock", rd_data[30], 0);
    check(rd_data == word(0, 0, 16, 0), "R2 readback layout", rd_data, word(0, 0, 16, 0));

    // enable at E0, request at E5, blocked write at E6, wrap at E256
    wr(word(1, 0, 16, 0));
    repeat (4) @(negedge clk);
    wr(word(1, 1, 16, 64));
    wr(word(1, 1, 32, 7));
    check(rd_data == word(1, 1, 16, 64), "R6 blocked write ignored", rd_data, word(1, 1, 16, 64));
    repeat (249) @(negedge clk);
    check(rd_data[30] == 1'b1, "R5 still pending before wrap", rd_data[30], 1);
    @(negedge clk);
    check(rd_data[30] == 1'b0, "R5 cleared at wrap edge", rd_data[30], 0);
    repeat (300) @(negedge clk);
    measure(256, hi, rises);
    check(hi == 191, "R6 pending config took effect", hi, 191);

    // vector table: live updates while enabled
    for (int v = 0; v < NV; v++) begin
      step = int'(VEC[v][39:28]);
      dv   = int'(VEC[v][27:20]);
      ehi  = int'(VEC[v][19:10]);
      per  = int'(VEC[v][9:0]);
      wr(word(1, 1, step, dv));
      poll_idle();
      repeat (2 * per + 4) @(negedge clk);
      measure(per, hi, rises);
      exp_rise = (ehi > 0 && ehi < per) ? 1 : 0;
      check(hi == ehi, "R4 high clocks per period", hi, ehi);
      check(rises == exp_rise, "R3 one rise per period", rises, exp_rise);
    end

    // R10 write without request: shadow only
    wr(word(1, 0, 16, 0));
    check(rd_data == word(1, 0, 16, 0), "R10 shadow readback", rd_data, word(1, 0, 16, 0));
    measure(256, hi, rises);
    check(hi == 1, "R10 active unchanged", hi, 1);

    // R8 disable forces low
    wr(word(0, 0, 16, 0));
    @(negedge clk);
    check(pwm_out == 1'b0, "R8 low after disable", pwm_out, 0);
    measure(300, hi, rises);
    check(hi == 0, "R8 stays low", hi, 0);

    // R9 zero step keeps output low while enabled
    wr(word(0, 1, 0, 100));
    @(negedge clk);
    wr(word(1, 0, 0, 100));
    repeat (10) @(negedge clk);
    measure(600, hi, rises);
    check(hi == 0, "R9 zero step low", hi, 0);
    check(rd_data == word(1, 0, 0, 100), "R2 readback enabled", rd_data, word(1, 0, 0, 100));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule